// File: doc/BRIEF.md
# Lockstep Multi-Cluster Fetch Sequencer

This block runs one logical wide-issue instruction stream as several independent fetch front ends, one per cluster. Every cluster owns a program counter, computes its own next address and presents that address to its private instruction memory port. The memory answers in the same cycle with a window of up to seven 32-bit units starting at that address, and with a miss flag. The cluster's local decoder reports how many of those units form the current slice. An align stage keeps exactly that many units and loads them into the cluster's instruction register.

The clusters never exchange slice sizes, because each one steps by its own slice length only. They do share one advance decision: when any cluster misses, no cluster moves, so all slices of one logical word always land in their instruction registers on the same edge. A branch unit can redirect each cluster to its own target address. A registered stall output tells the surrounding pipeline that the previous cycle did not advance.

Top module: `lockstep_seq`

## Requirements
- R1: While reset is held, every cluster's request address equals its own entry address from the parameter vector (cluster c at bits c*AW upward), all instruction-valid bits are 0 and the stall output is 0.
- R2: In a cycle where no cluster misses and a cluster's redirect is low, that cluster's address on the next cycle is its current address plus 4 times its 3-bit slice length, modulo 2^AW.
- R3: Each cluster's step depends only on its own slice length; clusters given different lengths in the same cycle step by different amounts.
- R4: On an advancing cycle the instruction register receives units 0 to L-1 of the response window (unit k at bits k*32 upward), where L is the slice length, and units L to 6 are zero. A length of 0 loads all zeros.
- R5: The instruction-valid bits of all clusters are always equal.
- R6: In a cycle where any miss flag is high, no cluster's address, instruction register or valid bit changes.
- R7: The stall output equals the OR of all miss flags from the previous cycle, and is 0 on the first cycle after reset.
- R8: In an advancing cycle a cluster whose redirect is high moves to its own redirect target on the next cycle.
- R9: A redirect that arrives in a cycle with any miss is ignored; the address does not change.
- R10: Instruction-valid bits stay 0 until the first cycle with no miss, and are 1 after it.
- R11: Address arithmetic wraps at 2^AW, so a step past the top of the address space continues from a low address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req_addr | output | N_CL*AW | Per-cluster fetch address |
| mem_rsp_data | input | N_CL*7*UNIT_W | Per-cluster response window, seven units starting at the address |
| mem_rsp_miss | input | N_CL | Per-cluster miss flag for the current address |
| op_len | input | N_CL*3 | Per-cluster slice length in 4-byte units (0 to 7) |
| redir_vld | input | N_CL | Per-cluster redirect request |
| redir_tgt | input | N_CL*AW | Per-cluster redirect target |
| ir_data | output | N_CL*7*UNIT_W | Per-cluster instruction register, aligned slice |
| ir_vld | output | N_CL | Per-cluster instruction register valid |
| stall_o | output | 1 | Registered OR of all miss flags |

## Verification
The bench gives each cluster a different slice length in the same cycle. A design that shared one length or summed the lengths would put some clusters on the wrong address. It raises a miss in only one cluster while the others hit, and also raises redirects during a miss. A design that stalled only the missing cluster, or accepted the redirect anyway, would let the clusters drift apart and lose lockstep. Zero-length slices, a first-cycle miss before any valid fetch, and a step across the top of the address space catch a missing align mask, an early valid bit and overflow handling that saturates instead of wrapping.

// File: rtl/lss_pkg.sv
package lss_pkg;
  localparam int SIZE_W     = 3;
  localparam int MAX_UNITS  = 7;
  localparam int UNIT_SHIFT = 2;
  localparam int BYTE_W     = SIZE_W + UNIT_SHIFT;

  typedef logic [SIZE_W-1:0] slice_len_t;

  // Slice length in bytes: encoded units times four.
  function automatic logic [BYTE_W-1:0] len_bytes(input slice_len_t len);
    return {len, {UNIT_SHIFT{1'b0}}};
  endfunction

  // True when unit k lies inside a slice of the given length.
  function automatic logic unit_kept(input int k, input slice_len_t len);
    return (k < int'(len));
  endfunction
endpackage

// File: rtl/slice_align.sv
module slice_align
  import lss_pkg::*;
#(
  parameter int UNIT_W = 32,
  localparam int WIN_W = MAX_UNITS * UNIT_W
) (
  input  logic [WIN_W-1:0] win_i,
  input  slice_len_t       len_i,
  output logic [WIN_W-1:0] slice_o
);
  for (genvar k = 0; k < MAX_UNITS; k++) begin : g_unit
    assign slice_o[k*UNIT_W +: UNIT_W] =
      unit_kept(k, len_i) ? win_i[k*UNIT_W +: UNIT_W] : '0;
  end
endmodule

// File: rtl/stall_join.sv
module stall_join #(
  parameter int N_CL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CL-1:0] miss_i,
  output logic            any_miss_o,
  output logic            stall_q_o
);
  assign any_miss_o = |miss_i;

  always_ff @(posedge clk) begin
    if (!rst_n) stall_q_o <= 1'b0;
    else        stall_q_o <= any_miss_o;
  end
endmodule

// File: rtl/cluster_front.sv
module cluster_front
  import lss_pkg::*;
#(
  parameter int          AW     = 16,
  parameter int          UNIT_W = 32,
  parameter logic [AW-1:0] ENTRY = '0,
  localparam int         WIN_W  = MAX_UNITS * UNIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance_i,
  input  slice_len_t       len_i,
  input  logic             redir_vld_i,
  input  logic [AW-1:0]    redir_tgt_i,
  input  logic [WIN_W-1:0] win_i,
  output logic [AW-1:0]    pc_o,
  output logic [WIN_W-1:0] ir_o,
  output logic             ir_vld_o
);
  logic [AW-1:0]    pc_q;
  logic [AW-1:0]    seq_pc;
  logic [AW-1:0]    nxt_pc;
  logic [WIN_W-1:0] aligned;

  slice_align #(.UNIT_W(UNIT_W)) u_align (
    .win_i   (win_i),
    .len_i   (len_i),
    .slice_o (aligned)
  );

  assign seq_pc = pc_q + AW'(len_bytes(len_i));
  assign nxt_pc = redir_vld_i ? redir_tgt_i : seq_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= ENTRY;
      ir_o     <= '0;
      ir_vld_o <= 1'b0;
    end else if (advance_i) begin
      pc_q     <= nxt_pc;
      ir_o     <= aligned;
      ir_vld_o <= 1'b1;
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/lockstep_seq.sv
module lockstep_seq
  import lss_pkg::*;
#(
  parameter int N_CL   = 3,
  parameter int AW     = 16,
  parameter int UNIT_W = 32,
  parameter logic [N_CL*AW-1:0] ENTRY_VEC = {16'h3000, 16'h2000, 16'h1000},
  localparam int WIN_W = MAX_UNITS * UNIT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [N_CL*AW-1:0]     mem_req_addr,
  input  logic [N_CL*WIN_W-1:0]  mem_rsp_data,
  input  logic [N_CL-1:0]        mem_rsp_miss,
  input  logic [N_CL*SIZE_W-1:0] op_len,
  input  logic [N_CL-1:0]        redir_vld,
  input  logic [N_CL*AW-1:0]     redir_tgt,
  output logic [N_CL*WIN_W-1:0]  ir_data,
  output logic [N_CL-1:0]        ir_vld,
  output logic                   stall_o
);
  logic any_miss;
  logic advance;

  stall_join #(.N_CL(N_CL)) u_join (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_i     (mem_rsp_miss),
    .any_miss_o (any_miss),
    .stall_q_o  (stall_o)
  );

  assign advance = !any_miss;

  for (genvar c = 0; c < N_CL; c++) begin : g_cl
    cluster_front #(
      .AW     (AW),
      .UNIT_W (UNIT_W),
      .ENTRY  (ENTRY_VEC[c*AW +: AW])
    ) u_front (
      .clk         (clk),
      .rst_n       (rst_n),
      .advance_i   (advance),
      .len_i       (op_len[c*SIZE_W +: SIZE_W]),
      .redir_vld_i (redir_vld[c]),
      .redir_tgt_i (redir_tgt[c*AW +: AW]),
      .win_i       (mem_rsp_data[c*WIN_W +: WIN_W]),
      .pc_o        (mem_req_addr[c*AW +: AW]),
      .ir_o        (ir_data[c*WIN_W +: WIN_W]),
      .ir_vld_o    (ir_vld[c])
    );
  end
endmodule

// File: rtl/lockstep_seq_chk.sv
module lockstep_seq_chk #(
  parameter int N_CL  = 3,
  parameter int AW    = 16,
  parameter int WIN_W = 224
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [N_CL*AW-1:0]    mem_req_addr,
  input logic [N_CL-1:0]       mem_rsp_miss,
  input logic [N_CL*3-1:0]     op_len,
  input logic [N_CL-1:0]       redir_vld,
  input logic [N_CL*AW-1:0]    redir_tgt,
  input logic [N_CL*WIN_W-1:0] ir_data,
  input logic [N_CL-1:0]       ir_vld,
  input logic                  stall_o,
  input logic                  any_miss,
  input logic                  advance
);
  AST_STALL_TRACKS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_rsp_miss) |=> stall_o); // R7
  AST_NO_STALL_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(|mem_rsp_miss) |=> !stall_o); // R7
  AST_HOLD_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    any_miss |=> ($stable(mem_req_addr) && $stable(ir_data) && $stable(ir_vld))); // R6
  AST_LOCKSTEP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_vld == '0) || (ir_vld == '1)); // R5
  AST_VALID_AFTER_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (ir_vld == '1)); // R10

  for (genvar c = 0; c < N_CL; c++) begin : g_c
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !redir_vld[c]) |=>
      mem_req_addr[c*AW +: AW] ==
        $past(mem_req_addr[c*AW +: AW]) + AW'({$past(op_len[c*3 +: 3]), 2'b00})); // R2
    AST_REDIRECT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && redir_vld[c]) |=>
      mem_req_addr[c*AW +: AW] == $past(redir_tgt[c*AW +: AW])); // R8
  end
endmodule

bind lockstep_seq lockstep_seq_chk #(
  .N_CL  (N_CL),
  .AW    (AW),
  .WIN_W (WIN_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req_addr (mem_req_addr),
  .mem_rsp_miss (mem_rsp_miss),
  .op_len       (op_len),
  .redir_vld    (redir_vld),
  .redir_tgt    (redir_tgt),
  .ir_data      (ir_data),
  .ir_vld       (ir_vld),
  .stall_o      (stall_o),
  .any_miss     (any_miss),
  .advance      (advance)
);

// File: tb/sim_lockstep_seq.sv
module sim_lockstep_seq;
  localparam int NC = 3;
  localparam int AW = 16;
  localparam int UW = 32;
  localparam int MU = 7;
  localparam int WW = MU * UW;
  localparam logic [NC*AW-1:0] ENTRIES = {16'h3000, 16'h2000, 16'h1000};

  // vector fields: {len2, len1, len0, miss[2:0], redir[2:0]}
  localparam logic [14:0] VEC [10] = '{
    {3'd2, 3'd2, 3'd2, 3'b001, 3'b000},
    {3'd3, 3'd2, 3'd1, 3'b000, 3'b000},
    {3'd5, 3'd0, 3'd7, 3'b000, 3'b000},
    {3'd4, 3'd4, 3'd4, 3'b010, 3'b000},
    {3'd4, 3'd4, 3'd4, 3'b010, 3'b111},
    {3'd1, 3'd3, 3'd2, 3'b000, 3'b101},
    {3'd0, 3'd0, 3'd0, 3'b000, 3'b000},
    {3'd6, 3'd6, 3'd6, 3'b100, 3'b010},
    {3'd7, 3'd1, 3'd6, 3'b000, 3'b010},
    {3'd3, 3'd3, 3'd3, 3'b111, 3'b000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NC*AW-1:0] mem_req_addr;
  logic [NC*WW-1:0] mem_rsp_data;
  logic [NC-1:0]    mem_rsp_miss = '0;
  logic [NC*3-1:0]  op_len = '0;
  logic [NC-1:0]    redir_vld = '0;
  logic [NC*AW-1:0] redir_tgt = '0;
  logic [NC*WW-1:0] ir_data;
  logic [NC-1:0]    ir_vld;
  logic             stall_o;

  lockstep_seq #(.N_CL(NC), .AW(AW), .UNIT_W(UW), .ENTRY_VEC(ENTRIES)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_req_addr(mem_req_addr), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_miss(mem_rsp_miss), .op_len(op_len), .redir_vld(redir_vld),
    .redir_tgt(redir_tgt), .ir_data(ir_data), .ir_vld(ir_vld), .stall_o(stall_o)
  );

  function automatic logic [UW-1:0] mword(input int c, input logic [AW-1:0] a);
    return {8'(c + 1), 8'h5A, a};
  endfunction

  // memory model: unit k of the window holds the word at address + 4k
  always_comb begin
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < MU; k++)
        mem_rsp_data[c*WW + k*UW +: UW] = mword(c, mem_req_addr[c*AW +: AW] + AW'(4*k));
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [AW-1:0] m_pc [NC];
  logic [WW-1:0] m_ir [NC];
  logic          m_vld;
  logic          m_stall;

  task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string pc_tag);
    for (int c = 0; c < NC; c++) begin
      chk(mem_req_addr[c*AW +: AW] == m_pc[c], pc_tag, WW'(mem_req_addr[c*AW +: AW]), WW'(m_pc[c]));
      chk(ir_data[c*WW +: WW] == m_ir[c], "R4 aligned slice", ir_data[c*WW +: WW], m_ir[c]);
    end
    chk(ir_vld == {NC{m_vld}}, m_vld ? "R5 lockstep valid" : "R10 valid before first fetch",
        WW'(ir_vld), WW'({NC{m_vld}}));
    chk(stall_o == m_stall, "R7 stall", WW'(stall_o), WW'(m_stall));
  endtask

  task automatic do_step(input logic [8:0] lens, input logic [2:0] miss, input logic [2:0] rd,
                         input logic [NC*AW-1:0] tgt);
    string tag;
    op_len = lens; mem_rsp_miss = miss; redir_vld = rd; redir_tgt = tgt;
    if (miss != 0) tag = (rd != 0) ? "R9 redirect ignored in miss" : "R6 hold on miss";
    else if (rd != 0) tag = "R8 redirect / R2,R3 own step";
    else tag = "R2,R3 own-length step";
    if (miss == 0) begin
      for (int c = 0; c < NC; c++) begin
        logic [2:0] l;
        l = lens[c*3 +: 3];
        m_ir[c] = '0;
        for (int k = 0; k < MU; k++)
          if (k < int'(l)) m_ir[c][k*UW +: UW] = mword(c, m_pc[c] + AW'(4*k));
        m_pc[c] = rd[c] ? tgt[c*AW +: AW] : m_pc[c] + AW'(int'(l) * 4);
      end
      m_vld = 1'b1;
    end
    m_stall = |miss;
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates even with misses and redirects applied
    mem_rsp_miss = '1; redir_vld = '1; op_len = '1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      m_pc[c] = ENTRIES[c*AW +: AW];
      m_ir[c] = '0;
      chk(mem_req_addr[c*AW +: AW] == m_pc[c], "R1 entry address",
          WW'(mem_req_addr[c*AW +: AW]), WW'(m_pc[c]));
    end
    chk(ir_vld == '0, "R1 valid cleared", WW'(ir_vld), '0);
    chk(stall_o == 1'b0, "R1 stall cleared", WW'(stall_o), '0);
    m_vld = 1'b0; m_stall = 1'b0;
    mem_rsp_miss = '0; redir_vld = '0; op_len = '0;
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < 10; i++) begin
      logic [NC*AW-1:0] t;
      for (int c = 0; c < NC; c++) t[c*AW +: AW] = 16'h4000 + AW'(c * 16'h100) + AW'(i * 16'h10);
      do_step(VEC[i][14:6], VEC[i][5:3], VEC[i][2:0], t);
    end

    // R11: wrap across the top of the address space
    do_step(9'b001_001_001, 3'b000, 3'b111, {16'hFFF0, 16'hFFF4, 16'hFFF8});
    do_step(9'b100_100_100, 3'b000, 3'b000, '0);
    chk(mem_req_addr[AW-1:0] == 16'h0008, "R11 wrap", WW'(mem_req_addr[AW-1:0]), WW'(16'h0008));
    chk(mem_req_addr[2*AW +: AW] == 16'h0000, "R11 wrap", WW'(mem_req_addr[2*AW +: AW]), WW'(16'h0000));

    // R6/R7: long miss in one cluster, then recovery with zero-length slices
    do_step(9'b111_111_111, 3'b100, 3'b000, '0);
    do_step(9'b111_111_111, 3'b100, 3'b011, '1);
    do_step(9'b000_000_000, 3'b000, 3'b000, '0);
    do_step(9'b010_001_111, 3'b000, 3'b000, '0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule